// File: doc/BRIEF.md
# Windowed Watchdog Timer

This block is a watchdog counter that software must service inside a restricted time slot. After every restart the count runs through a closed phase and then an open phase. The open phase is the last part of the period. A service write made while the window is open restarts the count. A service write made while it is closed is an error, and so is a write of the wrong byte or a count that runs out. Any of these errors produces a one-cycle internal reset request.

The configuration is taken while the external reset is low and is then fixed. It has two fields: a 3-bit period select and a 2-bit window select. One pairing of these fields is forbidden. When that pairing is captured, the block reports it and holds its reset request high. The first service write after a reset, or after a reset request, may arrive at any time before the period runs out. A parameter divides every period by a power of two so that short runs are possible.

Top module: `win_watchdog`

## Requirements
- R1: The period select and window select are captured only while `rst_n` is low. Changing them after reset release has no effect on behaviour.
- R2: With the window code in `cfg_window_sel`, the open part is the last fraction of the period and the closed part comes first. Code 0 gives 25% open, 1 gives 50%, 2 gives 75% and 3 gives 100%. The open window starts at count value P - (P/4)*(code+1), where P is the period.
- R3: A write of 0xAC (`KEY_BYTE`) while the window is open restarts the count from zero and causes no reset request.
- R4: After the first accepted write, a write of 0xAC while the window is closed raises `wdt_rst_req` in the next cycle.
- R5: `wdt_rst_req` is a single-cycle pulse on a legal configuration. After it, the count restarts from zero. Any write made in the pulse cycle is ignored.
- R6: A write of any byte other than 0xAC raises `wdt_rst_req` in the next cycle, whether the window is open or closed.
- R7: With period select S, the period P is 2^(10+S-SCALE_SHIFT) cycles. If the count reaches P-1 with no accepted write in that cycle, `wdt_rst_req` rises in the following cycle.
- R8: The first 0xAC write after reset release, or after a reset request, is accepted at any count value, and the exemption is then used up. Each reset request arms the exemption again.
- R9: Period select 0 combined with window code 0 is forbidden. In that case `cfg_err` reads 1, `wdt_rst_req` is held at 1 from the first cycle after release, and writes have no effect. For every legal configuration `cfg_err` reads 0.
- R10: While `rst_n` is low, `wdt_rst_req` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; the configuration is captured while it is low |
| cfg_period_sel | input | 3 | Period select S, period 2^(10+S-SCALE_SHIFT) cycles |
| cfg_window_sel | input | 2 | Window size code |
| clr_we | input | 1 | Write strobe for the service register |
| clr_data | input | 8 | Byte written to the service register |
| wdt_rst_req | output | 1 | Internal reset request |
| cfg_err | output | 1 | Forbidden configuration captured |

## Verification
A wrong count value or a wrong window bound appears at the ports only when a write lands near a window edge, or when the period ends. It then shows as a reset request that arrives one cycle early, one cycle late, or not at all. The bench therefore places writes on the last closed count and the first open count for every window code, and lets periods expire. A stale first-write flag shows on the very next early write after a request, as a missing or an extra pulse. Comparing every clock against the model turns each of these faults into a mismatch within one cycle of its first visible effect.

// File: rtl/win_wdog_pkg.sv
package win_wdog_pkg;

   localparam int unsigned NUM_PERIODS = 8;

   typedef logic [2:0] per_sel_t;
   typedef logic [1:0] win_sel_t;

   typedef struct packed {
      per_sel_t per;
      win_sel_t win;
   } wdog_cfg_t;

   // shortest period combined with the narrowest window is not allowed
   function automatic logic cfg_forbidden(input wdog_cfg_t c);
      return (c.per == 3'd0) && (c.win == 2'd0);
   endfunction

endpackage

// File: rtl/wdog_cfg_latch.sv
module wdog_cfg_latch
   import win_wdog_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  wdog_cfg_t cfg_in,
   output wdog_cfg_t cfg_q,
   output logic      err_q
);

   // sampled on every clock while reset is held, frozen afterwards
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cfg_q <= cfg_in;
         err_q <= cfg_forbidden(cfg_in);
      end
   end

endmodule

// File: rtl/wdog_limits.sv
module wdog_limits
   import win_wdog_pkg::*;
#(
   parameter int unsigned MIN_LOG2 = 10,
   parameter int unsigned CNT_W    = 18,
   parameter bit          REG_OUT  = 1'b1
)(
   input  logic             clk,
   input  wdog_cfg_t        cfg,
   output logic [CNT_W-1:0] last_cnt,
   output logic [CNT_W-1:0] open_from
);

   if (MIN_LOG2 < 2) begin : g_chk_min
      $error("wdog_limits: shortest period must be at least 4 cycles");
   end
   if (CNT_W < MIN_LOG2 + NUM_PERIODS) begin : g_chk_w
      $error("wdog_limits: counter too narrow for longest period");
   end

   logic [CNT_W-1:0] tbl [NUM_PERIODS];

   for (genvar g = 0; g < NUM_PERIODS; g++) begin : g_tbl
      localparam int unsigned SH = MIN_LOG2 + g;
      assign tbl[g] = {{(CNT_W-1){1'b0}}, 1'b1} << SH;
   end

   logic [CNT_W-1:0] period, quarter, open_len, last_c, open_c;

   always_comb begin
      period  = tbl[cfg.per];
      quarter = period >> 2;
      unique case (cfg.win)
         2'd0:    open_len = quarter;
         2'd1:    open_len = quarter << 1;
         2'd2:    open_len = (quarter << 1) + quarter;
         default: open_len = period;
      endcase
      last_c = period - CNT_W'(1);
      open_c = period - open_len;
   end

   if (REG_OUT) begin : g_reg
      always_ff @(posedge clk) begin
         last_cnt  <= last_c;
         open_from <= open_c;
      end
   end else begin : g_comb
      assign last_cnt  = last_c;
      assign open_from = open_c;
   end

endmodule

// File: rtl/wdog_window_cmp.sv
module wdog_window_cmp #(
   parameter int unsigned CNT_W = 18
)(
   input  logic [CNT_W-1:0] cnt,
   input  logic [CNT_W-1:0] open_from,
   output logic             win_open
);

   assign win_open = (cnt >= open_from);

endmodule

// File: rtl/wdog_ctrl.sv
module wdog_ctrl #(
   parameter int unsigned CNT_W = 18,
   parameter logic [7:0]  KEY   = 8'hAC
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             err,
   input  logic             clr_we,
   input  logic [7:0]       clr_data,
   input  logic             win_open,
   input  logic [CNT_W-1:0] last_cnt,
   output logic [CNT_W-1:0] cnt_q,
   output logic             first_q,
   output logic             req_q
);

   logic wr_live, key_hit, accept, abnormal, expire, trip;

   always_comb begin
      wr_live  = clr_we && !req_q;
      key_hit  = (clr_data == KEY);
      accept   = wr_live && key_hit && (first_q || win_open);
      abnormal = wr_live && !accept;
      expire   = !accept && (cnt_q == last_cnt);
      trip     = abnormal || expire;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q   <= '0;
         first_q <= 1'b1;
         req_q   <= 1'b0;
      end else if (err || trip) begin
         cnt_q   <= '0;
         first_q <= 1'b1;
         req_q   <= 1'b1;
      end else if (accept) begin
         cnt_q   <= '0;
         first_q <= 1'b0;
         req_q   <= 1'b0;
      end else begin
         cnt_q   <= cnt_q + CNT_W'(1);
         req_q   <= 1'b0;
      end
   end

endmodule

// File: rtl/win_watchdog.sv
module win_watchdog
   import win_wdog_pkg::*;
#(
   parameter int unsigned BASE_LOG2   = 10,
   parameter int unsigned SCALE_SHIFT = 0,
   parameter logic [7:0]  KEY_BYTE    = 8'hAC,
   parameter bit          REG_LIMITS  = 1'b1
)(
   input  logic       clk,
   input  logic       rst_n,
   input  logic [2:0] cfg_period_sel,
   input  logic [1:0] cfg_window_sel,
   input  logic       clr_we,
   input  logic [7:0] clr_data,
   output logic       wdt_rst_req,
   output logic       cfg_err
);

   localparam int unsigned MIN_LOG2 = BASE_LOG2 - SCALE_SHIFT;
   localparam int unsigned CNT_W    = MIN_LOG2 + NUM_PERIODS;

   if (SCALE_SHIFT + 2 > BASE_LOG2) begin : g_chk_scale
      $error("win_watchdog: SCALE_SHIFT leaves a period below 4 cycles");
   end

   wdog_cfg_t        cfg_in, cfg_q;
   logic [CNT_W-1:0] last_cnt, open_from, cnt_q;
   logic             win_open, first_q;

   assign cfg_in.per = cfg_period_sel;
   assign cfg_in.win = cfg_window_sel;

   wdog_cfg_latch u_cfg (
      .clk    (clk),
      .rst_n  (rst_n),
      .cfg_in (cfg_in),
      .cfg_q  (cfg_q),
      .err_q  (cfg_err)
   );

   wdog_limits #(
      .MIN_LOG2 (MIN_LOG2),
      .CNT_W    (CNT_W),
      .REG_OUT  (REG_LIMITS)
   ) u_lim (
      .clk       (clk),
      .cfg       (cfg_q),
      .last_cnt  (last_cnt),
      .open_from (open_from)
   );

   wdog_window_cmp #(.CNT_W(CNT_W)) u_win (
      .cnt       (cnt_q),
      .open_from (open_from),
      .win_open  (win_open)
   );

   wdog_ctrl #(.CNT_W(CNT_W), .KEY(KEY_BYTE)) u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .err      (cfg_err),
      .clr_we   (clr_we),
      .clr_data (clr_data),
      .win_open (win_open),
      .last_cnt (last_cnt),
      .cnt_q    (cnt_q),
      .first_q  (first_q),
      .req_q    (wdt_rst_req)
   );

endmodule

// File: rtl/wdog_checker.sv
module wdog_checker #(
   parameter int unsigned CNT_W = 18,
   parameter logic [7:0]  KEY   = 8'hAC
)(
   input logic             clk,
   input logic             rst_n,
   input logic             clr_we,
   input logic [7:0]       clr_data,
   input logic             req,
   input logic             err,
   input logic             first_q,
   input logic             win_open,
   input logic [CNT_W-1:0] cnt,
   input logic [CNT_W-1:0] last_cnt
);

   a_r3_open_key_restarts: assert property (@(posedge clk) disable iff (!rst_n)
      (!err && !req && clr_we && clr_data == KEY && win_open) |=> (!req && cnt == '0));

   a_r4_closed_key_trips: assert property (@(posedge clk) disable iff (!rst_n)
      (!err && !req && clr_we && clr_data == KEY && !first_q && !win_open) |=> req);

   a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      (req && !err) |=> !req);

   a_r6_wrong_byte_trips: assert property (@(posedge clk) disable iff (!rst_n)
      (!err && !req && clr_we && clr_data != KEY) |=> req);

   a_r7_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
      !err |-> (cnt <= last_cnt));

   a_r8_rearmed_after_req: assert property (@(posedge clk) disable iff (!rst_n)
      req |-> first_q);

   a_r9_forbidden_holds_req: assert property (@(posedge clk) disable iff (!rst_n)
      err |=> req);

endmodule

bind win_watchdog wdog_checker #(.CNT_W(CNT_W), .KEY(KEY_BYTE)) i_wdog_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .clr_we   (clr_we),
   .clr_data (clr_data),
   .req      (wdt_rst_req),
   .err      (cfg_err),
   .first_q  (first_q),
   .win_open (win_open),
   .cnt      (cnt_q),
   .last_cnt (last_cnt)
);

// File: tb/test_win_watchdog.sv
module test_win_watchdog;

   localparam int SHIFT = 6;
   localparam int MINL  = 10 - SHIFT;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [2:0] cfg_period_sel = 3'd0;
   logic [1:0] cfg_window_sel = 2'd1;
   logic       clr_we = 1'b0;
   logic [7:0] clr_data = 8'h00;
   logic       wdt_rst_req, cfg_err;

   always #10 clk = ~clk;

   win_watchdog #(.SCALE_SHIFT(SHIFT)) i_win_watchdog (
      .clk(clk), .rst_n(rst_n), .cfg_period_sel(cfg_period_sel),
      .cfg_window_sel(cfg_window_sel), .clr_we(clr_we), .clr_data(clr_data),
      .wdt_rst_req(wdt_rst_req), .cfg_err(cfg_err));

   int    n_tests = 0, n_fail = 0, cycles = 0;
   int    m_cnt, m_period, m_open;
   bit    m_first, m_req, m_err;
   string tag = "R10";
   bit    done = 0;

   always @(posedge clk) begin
      cycles++;
      if (cycles > 150000 && !done) begin
         n_fail++;
         $display("FAIL watchdog %s: actual hang, expected completion", tag);
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   task automatic compare();
      n_tests++;
      if (wdt_rst_req !== m_req || cfg_err !== m_err) begin
         n_fail++;
         $display("FAIL %s: actual req=%b err=%b, expected req=%b err=%b (count %0d)",
                  tag, wdt_rst_req, cfg_err, m_req, m_err, m_cnt);
      end
   endtask

   // behavioural reference of one clock edge
   task automatic model(input bit we, input logic [7:0] d);
      bit ok = 0, bad = 0;
      if (m_err) begin
         m_req = 1; m_cnt = 0; m_first = 1;
         return;
      end
      if (we && !m_req) begin
         if (d == 8'hAC && (m_first || m_cnt >= m_open)) ok = 1;
         else bad = 1;
      end
      if (!ok && m_cnt == m_period - 1) bad = 1;
      if (bad) begin
         m_cnt = 0; m_first = 1; m_req = 1;
      end else if (ok) begin
         m_cnt = 0; m_first = 0; m_req = 0;
      end else begin
         m_cnt++; m_req = 0;
      end
   endtask

   task automatic step(input bit we, input logic [7:0] d);
      clr_we = we; clr_data = d;
      @(posedge clk);
      model(we, d);
      @(negedge clk);
      clr_we = 0;
      compare();
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) step(0, 8'h00);
   endtask

   task automatic write_at(input int k, input logic [7:0] d);
      while (m_cnt != k) step(0, 8'h00);
      step(1, d);
   endtask

   task automatic do_reset(input int p, input int w);
      rst_n = 0;
      cfg_period_sel = p[2:0];
      cfg_window_sel = w[1:0];
      repeat (4) @(negedge clk);
      tag = "R10";
      n_tests++;
      if (wdt_rst_req !== 1'b0) begin
         n_fail++;
         $display("FAIL R10: actual req=%b during reset, expected 0", wdt_rst_req);
      end
      m_period = 1 << (MINL + p);
      m_open   = m_period - (m_period / 4) * (w + 1);
      m_cnt = 0; m_first = 1; m_req = 0;
      m_err = (p == 0 && w == 0);
      rst_n = 1;
   endtask

   initial begin
      @(negedge clk);
      // 16-cycle period, open from count 8
      do_reset(0, 1);
      tag = "R8";  write_at(2, 8'hAC);
      tag = "R4";  write_at(3, 8'hAC);
      tag = "R5";  step(1, 8'hAC); idle(2);
      tag = "R8";  write_at(3, 8'hAC);
      tag = "R3";  write_at(8, 8'hAC); write_at(15, 8'hAC);
      tag = "R2";  write_at(7, 8'hAC);
      tag = "R8";  write_at(1, 8'hAC);
      tag = "R6";  write_at(10, 8'h55); step(1, 8'hAB);
      tag = "R7";  idle(40);
      tag = "R1";  cfg_period_sel = 3'd3; cfg_window_sel = 2'd3;
      write_at(2, 8'hAC); write_at(5, 8'hAC); idle(20);
      // 32-cycle period, open from count 24
      do_reset(1, 0);
      tag = "R8";  write_at(0, 8'hAC);
      tag = "R2";  write_at(23, 8'hAC);
      tag = "R8";  write_at(1, 8'hAC);
      tag = "R3";  write_at(24, 8'hAC); write_at(31, 8'hAC);
      tag = "R7";  idle(40);
      // 16-cycle period, open from count 4
      do_reset(0, 2);
      tag = "R8";  write_at(0, 8'hAC);
      tag = "R2";  write_at(3, 8'hAC);
      tag = "R8";  write_at(2, 8'hAC);
      tag = "R3";  write_at(4, 8'hAC);
      // 64-cycle period, always open
      do_reset(2, 3);
      tag = "R8";  write_at(5, 8'hAC);
      tag = "R2";  write_at(0, 8'hAC); write_at(1, 8'hAC);
      tag = "R7";  idle(70);
      // forbidden configuration
      do_reset(0, 0);
      tag = "R9";  idle(4); step(1, 8'hAC); step(1, 8'h12); idle(20);
      // longest period
      do_reset(7, 3);
      tag = "R7";  idle(2100);
      tag = "R9";  do_reset(0, 3); idle(3);
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule